// File: doc/BRIEF.md
# H-Bridge Protection and Fault Supervisor

This block is the digital supervisor for a full H-bridge power stage. Each bridge leg has its own drive input, and the block turns it into a pair of gate enables: the high-side enable when the input is high, the low-side enable when it is low. Whenever the stage must not conduct, both enables of a leg drop and that output floats. Several conditions cause this: an active-low shutdown control, an active-low high-impedance control, a supply-low flag, a thermal trip flag, or an overcurrent event. The comparator flags and controls arrive already synchronised to the block clock.

Overcurrent does not latch. A flag that is sampled outside a blanking window starts a window that lasts a parameterised number of clocks. The bridge stays floated for the whole window, and the flag is ignored while the window runs. At the end of the window the flag is looked at again. If it has gone, drive resumes. If it is still high, a new window starts at once, and this repeats without limit. A two-bit active-low fault code reports the most urgent condition. The thermal scheme has two levels: a warning level that only changes the code, and a trip level that also floats the outputs.

Top module: `hbridge_supervisor`

## Requirements
- R1: The fault code reports overcurrent (active or blanking) as 2'b00, supply-low as 2'b01, and thermal warning or trip as 2'b10. Normal operation reads 2'b11. When several conditions are present, the first in that order wins. Shutdown and the high-impedance control do not change the code.
- R2: An overcurrent flag sampled at a clock edge while no window is running starts a window. From that edge through the following BLANK_CYCLES edges (BLANK_CYCLES+1 cycles in all), every gate enable is 0 and the code is 2'b00.
- R3: Overcurrent pulses that arrive during a window have no effect. If the flag is low at the first edge after the window, drive and code 2'b11 return at that edge.
- R4: If the overcurrent flag is still high at the first edge after a window, a new window of the same length starts at that edge, and the outputs stay floated throughout.
- R5: While the supply-low flag is high, all enables are 0 and the code is 2'b01 (unless there is overcurrent). Both return to normal one cycle after the flag clears.
- R6: The thermal warning flag sets code 2'b10 while the legs keep following their inputs. It clears one cycle after the flag drops.
- R7: The thermal trip flag forces all enables to 0 and reports code 2'b10.
- R8: Shutdown low forces all enables to 0 and raises low_power. Shutdown high drops low_power.
- R9: The high-impedance control held low forces all enables to 0.
- R10: With no disabling condition present, each leg independently drives hi_en = leg_in and lo_en = not leg_in, one clock after sampling.
- R11: The high-side and low-side enables of one leg are never both 1.
- R12: During reset all enables are 0, the code is 2'b11 and low_power is 0. The blanking timer is cleared, so drive follows the inputs on the first cycle after reset is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| leg_in | input | NUM_LEGS | Per-leg drive request, 1 = pull to supply |
| shutdown_n | input | 1 | Active-low shutdown and low-power request |
| hiz_n | input | 1 | Active-low float request for all legs |
| oc_flag | input | 1 | Overcurrent comparator flag |
| uv_flag | input | 1 | Supply-low comparator flag |
| ot_warn_flag | input | 1 | Thermal warning level flag |
| ot_trip_flag | input | 1 | Thermal trip level flag |
| hi_en | output | NUM_LEGS | Per-leg high-side gate enable |
| lo_en | output | NUM_LEGS | Per-leg low-side gate enable |
| fault_code | output | 2 | Active-low fault code |
| low_power | output | 1 | Low-power state indicator |

## Verification
The hardest behaviour to reach from the ports is what happens at the window boundary. The bench has to show that a flag pulse inside a window is discarded. It also has to show that a flag held across the boundary re-arms a second window at exactly the first free edge, and that a reset in mid-window leaves no leftover blanking. The bench counts edges from one injected single-cycle pulse and places further pulses at chosen offsets inside the window. It also holds the flag across the boundary and measures the full 2*BLANK_CYCLES+2 cycle float. Reset is asserted partway through a window, and drive is checked on the very first cycle after release. An exhaustive sweep over every combination of the static flags, the controls and the leg inputs covers the priority encoding.

// File: rtl/hbs_pkg.sv
package hbs_pkg;

   typedef enum logic [1:0] {
      FC_OVERCURRENT = 2'b00,
      FC_SUPPLY_LOW  = 2'b01,
      FC_THERMAL     = 2'b10,
      FC_NORMAL      = 2'b11
   } fault_code_t;

   typedef enum logic {
      BLK_IDLE  = 1'b0,
      BLK_HOLD  = 1'b1
   } blank_state_t;

endpackage

// File: rtl/hbs_oc_blank.sv
module hbs_oc_blank #(
   parameter int BLANK_CYCLES = 500,
   localparam int CNT_W = (BLANK_CYCLES > 1) ? $clog2(BLANK_CYCLES) : 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             oc_flag,
   output logic             oc_hold,
   output logic             blanking,
   output logic [CNT_W-1:0] blank_cnt
);
   import hbs_pkg::*;

   localparam logic [CNT_W-1:0] LOAD_VAL = CNT_W'(BLANK_CYCLES - 1);

   blank_state_t state_q;
   logic         trip;

   initial begin : chk_blank_len
      assert (BLANK_CYCLES >= 2)
         else $fatal(1, "hbs_oc_blank: BLANK_CYCLES must be at least 2");
   end

   assign blanking = (state_q == BLK_HOLD);
   // a new window only arms when none is running; the flag is ignored inside
   assign trip     = oc_flag && !blanking;
   assign oc_hold  = trip || blanking;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q   <= BLK_IDLE;
         blank_cnt <= '0;
      end else begin
         unique case (state_q)
            BLK_IDLE: begin
               if (trip) begin
                  state_q   <= BLK_HOLD;
                  blank_cnt <= LOAD_VAL;
               end
            end
            BLK_HOLD: begin
               if (blank_cnt == '0) begin
                  state_q <= BLK_IDLE;
               end else begin
                  blank_cnt <= blank_cnt - 1'b1;
               end
            end
            default: begin
               state_q   <= BLK_IDLE;
               blank_cnt <= '0;
            end
         endcase
      end
   end

endmodule

// File: rtl/hbs_fault_encode.sv
module hbs_fault_encode (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       oc_hold,
   input  logic       uv_flag,
   input  logic       ot_warn_flag,
   input  logic       ot_trip_flag,
   input  logic       shutdown_n,
   output logic [1:0] fault_code,
   output logic       low_power
);
   import hbs_pkg::*;

   fault_code_t code_d;

   always_comb begin
      if (oc_hold)                         code_d = FC_OVERCURRENT;
      else if (uv_flag)                    code_d = FC_SUPPLY_LOW;
      else if (ot_warn_flag || ot_trip_flag) code_d = FC_THERMAL;
      else                                 code_d = FC_NORMAL;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         fault_code <= FC_NORMAL;
         low_power  <= 1'b0;
      end else begin
         fault_code <= code_d;
         low_power  <= !shutdown_n;
      end
   end

endmodule

// File: rtl/hbs_leg_stage.sv
module hbs_leg_stage (
   input  logic clk,
   input  logic rst_n,
   input  logic drive_ok,
   input  logic leg_req,
   output logic hi_en,
   output logic lo_en
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hi_en <= 1'b0;
         lo_en <= 1'b0;
      end else begin
         hi_en <= drive_ok &&  leg_req;
         lo_en <= drive_ok && !leg_req;
      end
   end

endmodule

// File: rtl/hbridge_supervisor.sv
module hbridge_supervisor #(
   parameter int NUM_LEGS     = 2,
   parameter int BLANK_CYCLES = 500
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [NUM_LEGS-1:0] leg_in,
   input  logic                shutdown_n,
   input  logic                hiz_n,
   input  logic                oc_flag,
   input  logic                uv_flag,
   input  logic                ot_warn_flag,
   input  logic                ot_trip_flag,
   output logic [NUM_LEGS-1:0] hi_en,
   output logic [NUM_LEGS-1:0] lo_en,
   output logic [1:0]          fault_code,
   output logic                low_power
);
   localparam int CNT_W = (BLANK_CYCLES > 1) ? $clog2(BLANK_CYCLES) : 1;

   logic             oc_hold;
   logic             blanking;
   logic [CNT_W-1:0] blank_cnt;
   logic             drive_ok;

   initial begin : chk_legs
      assert (NUM_LEGS >= 1)
         else $fatal(1, "hbridge_supervisor: NUM_LEGS must be at least 1");
   end

   hbs_oc_blank #(.BLANK_CYCLES(BLANK_CYCLES)) u_blank (
      .clk       (clk),
      .rst_n     (rst_n),
      .oc_flag   (oc_flag),
      .oc_hold   (oc_hold),
      .blanking  (blanking),
      .blank_cnt (blank_cnt)
   );

   hbs_fault_encode u_code (
      .clk          (clk),
      .rst_n        (rst_n),
      .oc_hold      (oc_hold),
      .uv_flag      (uv_flag),
      .ot_warn_flag (ot_warn_flag),
      .ot_trip_flag (ot_trip_flag),
      .shutdown_n   (shutdown_n),
      .fault_code   (fault_code),
      .low_power    (low_power)
   );

   // thermal warning alone leaves drive untouched
   assign drive_ok = shutdown_n && hiz_n && !uv_flag && !ot_trip_flag && !oc_hold;

   for (genvar g = 0; g < NUM_LEGS; g++) begin : g_leg
      hbs_leg_stage u_leg (
         .clk      (clk),
         .rst_n    (rst_n),
         .drive_ok (drive_ok),
         .leg_req  (leg_in[g]),
         .hi_en    (hi_en[g]),
         .lo_en    (lo_en[g])
      );
   end

endmodule

// File: rtl/hbs_checker.sv
module hbs_checker #(
   parameter int NUM_LEGS     = 2,
   parameter int BLANK_CYCLES = 500,
   localparam int CNT_W = (BLANK_CYCLES > 1) ? $clog2(BLANK_CYCLES) : 1
) (
   input logic                clk,
   input logic                rst_n,
   input logic [NUM_LEGS-1:0] leg_in,
   input logic                shutdown_n,
   input logic                hiz_n,
   input logic                oc_flag,
   input logic                uv_flag,
   input logic                ot_warn_flag,
   input logic                ot_trip_flag,
   input logic                blanking,
   input logic [CNT_W-1:0]    blank_cnt,
   input logic [NUM_LEGS-1:0] hi_en,
   input logic [NUM_LEGS-1:0] lo_en,
   input logic [1:0]          fault_code,
   input logic                low_power
);

   assert_oc_code_R2: assert property (@(posedge clk) disable iff (!rst_n)
      oc_flag |=> fault_code == 2'b00);

   assert_oc_float_R2: assert property (@(posedge clk) disable iff (!rst_n)
      oc_flag |=> (hi_en == '0) && (lo_en == '0));

   assert_blank_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(blanking) |-> blank_cnt == CNT_W'(BLANK_CYCLES - 1));

   assert_blank_float_R4: assert property (@(posedge clk) disable iff (!rst_n)
      blanking |=> (hi_en == '0) && (lo_en == '0) && (fault_code == 2'b00));

   assert_uv_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (uv_flag && !oc_flag && !blanking) |=>
         (fault_code == 2'b01) && (hi_en == '0) && (lo_en == '0));

   assert_warn_code_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (ot_warn_flag && !uv_flag && !oc_flag && !blanking) |=> fault_code == 2'b10);

   assert_trip_R7: assert property (@(posedge clk) disable iff (!rst_n)
      ot_trip_flag |=> (hi_en == '0) && (lo_en == '0));

   assert_shutdown_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !shutdown_n |=> low_power && (hi_en == '0) && (lo_en == '0));

   assert_hiz_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !hiz_n |=> (hi_en == '0) && (lo_en == '0));

   assert_follow_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (shutdown_n && hiz_n && !uv_flag && !ot_trip_flag && !oc_flag && !blanking) |=>
         (hi_en == $past(leg_in)) && (lo_en == ~$past(leg_in)));

   assert_leg_exclusive_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (hi_en & lo_en) == '0);

endmodule

bind hbridge_supervisor hbs_checker #(
   .NUM_LEGS     (NUM_LEGS),
   .BLANK_CYCLES (BLANK_CYCLES)
) u_hbs_checker (
   .clk          (clk),
   .rst_n        (rst_n),
   .leg_in       (leg_in),
   .shutdown_n   (shutdown_n),
   .hiz_n        (hiz_n),
   .oc_flag      (oc_flag),
   .uv_flag      (uv_flag),
   .ot_warn_flag (ot_warn_flag),
   .ot_trip_flag (ot_trip_flag),
   .blanking     (blanking),
   .blank_cnt    (blank_cnt),
   .hi_en        (hi_en),
   .lo_en        (lo_en),
   .fault_code   (fault_code),
   .low_power    (low_power)
);

// File: tb/tb_hbridge_supervisor.sv
`timescale 1ns/1ps
module tb_hbridge_supervisor;
   localparam int NL = 2;
   localparam int NB = 5;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [NL-1:0] leg_in = '0;
   logic          shutdown_n = 1'b1, hiz_n = 1'b1;
   logic          oc_flag = 1'b0, uv_flag = 1'b0, ot_warn_flag = 1'b0, ot_trip_flag = 1'b0;
   logic [NL-1:0] hi_en, lo_en;
   logic [1:0]    fault_code;
   logic          low_power;

   int n_checks = 0;
   int n_errors = 0;
   bit done = 0;

   always #4 clk = ~clk;

   hbridge_supervisor #(.NUM_LEGS(NL), .BLANK_CYCLES(NB)) dut (
      .clk(clk), .rst_n(rst_n), .leg_in(leg_in), .shutdown_n(shutdown_n),
      .hiz_n(hiz_n), .oc_flag(oc_flag), .uv_flag(uv_flag),
      .ot_warn_flag(ot_warn_flag), .ot_trip_flag(ot_trip_flag),
      .hi_en(hi_en), .lo_en(lo_en), .fault_code(fault_code), .low_power(low_power)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_errors++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   // outputs in one word: {lo_en, hi_en, fault_code}
   function automatic logic [31:0] pack(input logic [NL-1:0] h, input logic [NL-1:0] l,
                                        input logic [1:0] c);
      return {26'd0, l, h, c};
   endfunction

   task automatic check_drive(input string tag, input logic [NL-1:0] lin, input logic [1:0] code);
      chk(tag, pack(hi_en, lo_en, fault_code), pack(lin, ~lin, code));
      chk("R11", {30'd0, hi_en & lo_en}, 32'd0);
   endtask

   task automatic check_float(input string tag, input logic [1:0] code);
      chk(tag, pack(hi_en, lo_en, fault_code), pack('0, '0, code));
      chk("R11", {30'd0, hi_en & lo_en}, 32'd0);
   endtask

   task automatic normal_inputs(input logic [NL-1:0] lin);
      leg_in = lin; shutdown_n = 1'b1; hiz_n = 1'b1; oc_flag = 1'b0;
      uv_flag = 1'b0; ot_warn_flag = 1'b0; ot_trip_flag = 1'b0;
   endtask

   initial begin : watchdog
      #(200000 * 8);
      if (!done) begin
         n_checks++; n_errors++;
         $display("FAIL watchdog: actual running expected finished");
         $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
         $finish;
      end
   end

   initial begin : stim
      // R12 reset state
      repeat (3) @(negedge clk);
      check_float("R12 reset", 2'b11);
      chk("R12 low_power", {31'd0, low_power}, 32'd0);
      normal_inputs(2'b01);
      @(negedge clk); rst_n = 1'b1;
      @(negedge clk);
      check_drive("R12 first cycle", 2'b01, 2'b11);

      // exhaustive static sweep: v = {hiz_n, shutdown_n, trip, warn, uv, leg_in}
      for (int v = 0; v < 128; v++) begin
         logic [NL-1:0] lin;
         logic ok;
         logic [1:0] code;
         string tag;
         @(negedge clk);
         lin = v[1:0];
         leg_in = lin; uv_flag = v[2]; ot_warn_flag = v[3]; ot_trip_flag = v[4];
         shutdown_n = v[5]; hiz_n = v[6]; oc_flag = 1'b0;
         @(negedge clk);
         ok = !v[2] && !v[4] && v[5] && v[6];
         code = v[2] ? 2'b01 : ((v[3] || v[4]) ? 2'b10 : 2'b11);
         if (v[2]) tag = "R5";
         else if (v[4]) tag = "R7";
         else if (!v[5]) tag = "R8";
         else if (!v[6]) tag = "R9";
         else if (v[3]) tag = "R6";
         else tag = "R10";
         chk(tag, {30'd0, hi_en}, ok ? {30'd0, lin} : 32'd0);
         chk(tag, {30'd0, lo_en}, ok ? {30'd0, ~lin} : 32'd0);
         chk("R1", {30'd0, fault_code}, {30'd0, code});
         chk("R8 low_power", {31'd0, low_power}, {31'd0, !v[5]});
         chk("R11", {30'd0, hi_en & lo_en}, 32'd0);
      end

      // R10 PWM pattern at full rate, legs independent
      for (int k = 0; k < 8; k++) begin
         @(negedge clk); normal_inputs(NL'(k ^ (k >> 1)));
         @(negedge clk); check_drive("R10 pwm", NL'(k ^ (k >> 1)), 2'b11);
      end

      // R2 single pulse: float for NB+1 cycles, then R3 resume
      @(negedge clk); normal_inputs(2'b10); oc_flag = 1'b1;
      @(negedge clk); oc_flag = 1'b0;
      check_float("R2 window start", 2'b00);
      for (int k = 1; k <= NB; k++) begin
         @(negedge clk); check_float("R2 window", 2'b00);
      end
      @(negedge clk); check_drive("R3 resume", 2'b10, 2'b11);

      // R3 pulses inside window are ignored; R1 priority over uv/thermal
      @(negedge clk); normal_inputs(2'b01); oc_flag = 1'b1; uv_flag = 1'b1; ot_warn_flag = 1'b1;
      @(negedge clk); oc_flag = 1'b0;
      check_float("R1 oc over uv", 2'b00);
      for (int k = 1; k <= NB; k++) begin
         @(negedge clk);
         check_float("R3 window", 2'b00);
         oc_flag = (k == 2 || k == NB - 1);
      end
      @(negedge clk); uv_flag = 1'b0; oc_flag = 1'b0;
      check_float("R1 uv after window", 2'b01);
      @(negedge clk); check_drive("R6 warn drives", 2'b01, 2'b10);
      ot_warn_flag = 1'b0;
      @(negedge clk); check_drive("R6 warn clears", 2'b01, 2'b11);

      // R4 flag held across the boundary re-arms: 2*NB+2 floated cycles
      @(negedge clk); normal_inputs(2'b11); oc_flag = 1'b1;
      for (int k = 0; k <= NB + 1; k++) begin
         @(negedge clk); check_float("R4 held", 2'b00);
      end
      oc_flag = 1'b0;
      for (int k = NB + 2; k <= 2 * NB + 1; k++) begin
         @(negedge clk); check_float("R4 rearmed window", 2'b00);
      end
      @(negedge clk); check_drive("R4 resume", 2'b11, 2'b11);

      // R12 reset in mid-window clears the timer
      @(negedge clk); normal_inputs(2'b00); oc_flag = 1'b1;
      @(negedge clk); oc_flag = 1'b0;
      @(negedge clk); rst_n = 1'b0;
      @(negedge clk); check_float("R12 reset mid-window", 2'b11);
      rst_n = 1'b1;
      @(negedge clk); check_drive("R12 timer cleared", 2'b00, 2'b11);

      // R7 trip with warning, then release
      @(negedge clk); ot_trip_flag = 1'b1; leg_in = 2'b01;
      @(negedge clk); check_float("R7 trip", 2'b10);
      ot_trip_flag = 1'b0;
      @(negedge clk); check_drive("R7 release", 2'b01, 2'b11);

      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
   end

endmodule